// File: doc/BRIEF.md
# Maskable Interrupt and Discrete Output Port Bank

This block gives an accumulator machine its interrupt latching and its discrete output lines. The processor reaches it through a port I/O instruction that carries a 9-bit address field. The two low address bits choose the direction: `10` is an output-port write and `11` is an input-port read. Six selector bits above them name the register. Address bit 8 is ignored.

Twelve interrupt lines are captured on their rising edges into a storage register. Bit 0 is the minor-loop timer position and bits 1 to 11 are the numbered sources. An inhibit mask, which may hold any combination of bits, keeps latched sources from raising the request line without discarding them. Software clears latched sources by writing ones to a clear port, and reads the storage register back through an input port.

The same bank holds a discrete output register, changed bit by bit through separate set and clear ports, and a 15-bit switch-selector command register. One read port returns the switch-selector and discrete-output registers together.

Top module: `irq_dio_bank`

## Requirements
- R1: After reset every register is 0, `irq_req` is 0, `dout` is 0, and both read ports return 0.
- R2: A rising edge on `irq_in[i]` sets storage bit i at the next clock. A line held high does not set the bit again after it is cleared. A read with `port_addr[1:0]=11` and `port_addr[7:2]=23` returns the storage in `rd_data[11:0]`, with the upper bits 0.
- R3: `irq_req` is high exactly when at least one latched storage bit has its inhibit bit at 0.
- R4: A write with selector 14 replaces the whole inhibit mask with `wr_data[11:0]`. A bit at 1 masks its source, and a bit at 0 enables it again. Latched storage is unchanged by the write.
- R5: A write with selector 6 clears exactly the storage bits whose `wr_data` bit is 1 and leaves the other bits alone.
- R6: A rising edge on a source in the same cycle as a selector-6 write that clears that bit leaves the bit latched.
- R7: A write with selector 3 sets the `dout` bits given by 1s in `wr_data[7:0]`. A write with selector 2 clears them. Bits written as 0 keep their value.
- R8: A write with selector 7 loads `wr_data[14:0]` into the switch-selector register. A read with selector 10 returns that register in `rd_data[14:0]` and `dout` in `rd_data[22:15]`, with the upper bits 0.
- R9: A write takes effect only when `port_addr[1:0]=10` and the selector is one of 2, 3, 6, 7 or 14. Any other address leaves every register unchanged. `port_addr[8]` does not affect decoding.
- R10: `rd_data` is 0 whenever `rd_en` is low, and whenever the read address is not one of the two read ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 12 | Interrupt source lines, captured on rising edge |
| port_addr | input | 9 | Port address field of the I/O instruction |
| wr_en | input | 1 | Output-port write strobe |
| rd_en | input | 1 | Input-port read strobe |
| wr_data | input | 26 | Accumulator data written to a port |
| rd_data | output | 26 | Data returned by an input port |
| irq_req | output | 1 | Interrupt request: OR of unmasked latched sources |
| dout | output | 8 | Discrete output lines |

## Verification
The bench sweeps all 4096 inhibit masks against a full storage register. A decoder that inverts the mask sense, or lets the mask discard latched bits, shows up as a wrong request level or a changed readback. Clear and set/clear ports are driven with mixed patterns. A write-as-value implementation would wipe bits that were written as 0.

A source edge is made to coincide with a clear of that bit. A clear-wins priority would lose that interrupt. A line held high across a clear must not relatch, which catches a level-sensitive capture. Writes with the wrong direction bits or an unknown selector, and writes with address bit 8 set, expose loose address decoding.

// File: rtl/irq_dio_pkg.sv
`timescale 1ns/1ps
package irq_dio_pkg;
   // selector codes carried in port_addr[7:2]
   localparam logic [5:0] SEL_DOUT_CLR = 6'd2;
   localparam logic [5:0] SEL_DOUT_SET = 6'd3;
   localparam logic [5:0] SEL_IRQ_CLR  = 6'd6;
   localparam logic [5:0] SEL_SS_LOAD  = 6'd7;
   localparam logic [5:0] SEL_OUT_RB   = 6'd10;
   localparam logic [5:0] SEL_INHIBIT  = 6'd14;
   localparam logic [5:0] SEL_IRQ_RD   = 6'd23;

   localparam logic [1:0] DIR_WRITE = 2'b10;
   localparam logic [1:0] DIR_READ  = 2'b11;

   typedef struct packed {
      logic dout_clr;
      logic dout_set;
      logic irq_clr;
      logic ss_load;
      logic inhibit_wr;
      logic rd_out;
      logic rd_irq;
   } port_strb_t;
endpackage

// File: rtl/port_decode.sv
`timescale 1ns/1ps
module port_decode
   import irq_dio_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   output port_strb_t        strb
);
   logic [5:0] sel;
   logic       is_wr;
   logic       is_rd;

   always_comb begin
      sel   = addr[7:2];
      is_wr = wr_en && (addr[1:0] == DIR_WRITE);
      is_rd = rd_en && (addr[1:0] == DIR_READ);
      strb.dout_clr   = is_wr && (sel == SEL_DOUT_CLR);
      strb.dout_set   = is_wr && (sel == SEL_DOUT_SET);
      strb.irq_clr    = is_wr && (sel == SEL_IRQ_CLR);
      strb.ss_load    = is_wr && (sel == SEL_SS_LOAD);
      strb.inhibit_wr = is_wr && (sel == SEL_INHIBIT);
      strb.rd_out     = is_rd && (sel == SEL_OUT_RB);
      strb.rd_irq     = is_rd && (sel == SEL_IRQ_RD);
   end
endmodule

// File: rtl/irq_capture.sv
`timescale 1ns/1ps
module irq_capture #(
   parameter int N           = 12,
   parameter bit EDGE_DETECT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lines,
   output logic [N-1:0] hits
);
   generate
      if (EDGE_DETECT) begin : g_edge
         logic [N-1:0] prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= '0;
            else        prev_q <= lines;
         end
         assign hits = lines & ~prev_q;
      end else begin : g_level
         assign hits = lines;
      end
   endgenerate
endmodule

// File: rtl/set_clr_reg.sv
`timescale 1ns/1ps
module set_clr_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic [W-1:0] set_bits,
   input  logic         clr_en,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] q
);
   logic [W-1:0] set_m;
   logic [W-1:0] clr_m;

   assign set_m = set_en ? set_bits : '0;
   assign clr_m = clr_en ? clr_bits : '0;

   // set has priority over clear for the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr_m) | set_m;
   end
endmodule

// File: rtl/irq_dio_bank.sv
`timescale 1ns/1ps
module irq_dio_bank
   import irq_dio_pkg::*;
#(
   parameter int NUM_IRQ     = 12,
   parameter int ADDR_W      = 9,
   parameter int DATA_W      = 26,
   parameter int SS_W        = 15,
   parameter int DOUT_W      = 8,
   parameter bit EDGE_DETECT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IRQ-1:0] irq_in,
   input  logic [ADDR_W-1:0] port_addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_req,
   output logic [DOUT_W-1:0] dout
);
   localparam int RB_W = SS_W + DOUT_W;

   generate
      if (RB_W > DATA_W) begin : g_bad_rb
         $error("switch-selector plus discrete width exceeds data width");
      end
      if (NUM_IRQ > DATA_W) begin : g_bad_irq
         $error("interrupt count exceeds data width");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("address field must cover bits 0 to 7");
      end
   endgenerate

   port_strb_t         strb;
   logic [NUM_IRQ-1:0] hits;
   logic [NUM_IRQ-1:0] lat_q;
   logic [NUM_IRQ-1:0] inhib_q;
   logic [SS_W-1:0]    ss_q;
   logic [DOUT_W-1:0]  dout_q;

   port_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr  (port_addr),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .strb  (strb)
   );

   irq_capture #(.N(NUM_IRQ), .EDGE_DETECT(EDGE_DETECT)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .lines (irq_in),
      .hits  (hits)
   );

   set_clr_reg #(.W(NUM_IRQ)) u_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (1'b1),
      .set_bits (hits),
      .clr_en   (strb.irq_clr),
      .clr_bits (wr_data[NUM_IRQ-1:0]),
      .q        (lat_q)
   );

   set_clr_reg #(.W(DOUT_W)) u_dout (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (strb.dout_set),
      .set_bits (wr_data[DOUT_W-1:0]),
      .clr_en   (strb.dout_clr),
      .clr_bits (wr_data[DOUT_W-1:0]),
      .q        (dout_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inhib_q <= '0;
         ss_q    <= '0;
      end else begin
         if (strb.inhibit_wr) inhib_q <= wr_data[NUM_IRQ-1:0];
         if (strb.ss_load)    ss_q    <= wr_data[SS_W-1:0];
      end
   end

   always_comb begin
      rd_data = '0;
      if (strb.rd_irq)      rd_data[NUM_IRQ-1:0] = lat_q;
      else if (strb.rd_out) rd_data[RB_W-1:0]    = {dout_q, ss_q};
   end

   assign irq_req = |(lat_q & ~inhib_q);
   assign dout    = dout_q;
endmodule

// File: rtl/irq_dio_bank_chk.sv
`timescale 1ns/1ps
module irq_dio_bank_chk
   import irq_dio_pkg::*;
#(
   parameter int NUM_IRQ = 12,
   parameter int ADDR_W  = 9,
   parameter int DATA_W  = 26,
   parameter int SS_W    = 15,
   parameter int DOUT_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_IRQ-1:0] irq_in,
   input logic [ADDR_W-1:0]  port_addr,
   input logic               wr_en,
   input logic               rd_en,
   input logic [DATA_W-1:0]  wr_data,
   input logic [DATA_W-1:0]  rd_data,
   input logic               irq_req,
   input logic [DOUT_W-1:0]  dout,
   input logic [NUM_IRQ-1:0] lat_q,
   input logic [SS_W-1:0]    ss_q
);
   logic wr_ok;
   assign wr_ok = wr_en && (port_addr[1:0] == DIR_WRITE);

   // R4
   inhibit_all_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && port_addr[7:2] == SEL_INHIBIT && wr_data[NUM_IRQ-1:0] == '1) |=> !irq_req);

   // R5
   clear_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && port_addr[7:2] == SEL_IRQ_CLR && wr_data[NUM_IRQ-1:0] == '1 && irq_in == '0)
      |=> lat_q == '0);

   // R6
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ok && port_addr[7:2] == SEL_IRQ_CLR) |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

   // R7
   dout_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && port_addr[7:2] == SEL_DOUT_SET)
      |=> ((dout & $past(wr_data[DOUT_W-1:0])) == $past(wr_data[DOUT_W-1:0])));

   // R8
   ss_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && port_addr[7:2] == SEL_SS_LOAD) |=> ss_q == $past(wr_data[SS_W-1:0]));

   // R10
   rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> rd_data == '0);

   // R3
   irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (lat_q != '0));
endmodule

bind irq_dio_bank irq_dio_bank_chk #(
   .NUM_IRQ (NUM_IRQ),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .SS_W    (SS_W),
   .DOUT_W  (DOUT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_in    (irq_in),
   .port_addr (port_addr),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .wr_data   (wr_data),
   .rd_data   (rd_data),
   .irq_req   (irq_req),
   .dout      (dout),
   .lat_q     (lat_q),
   .ss_q      (ss_q)
);

// File: tb/irq_dio_bank_tb.sv
`timescale 1ns/1ps
module irq_dio_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] irq_in = '0;
   logic [8:0]  port_addr = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [25:0] wr_data = '0;
   logic [25:0] rd_data;
   logic        irq_req;
   logic [7:0]  dout;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   logic [11:0] exp_lat = '0;
   logic [11:0] exp_inh = '0;
   logic [7:0]  exp_dout = '0;
   logic [14:0] exp_ss = '0;

   always #2.5 clk = ~clk;

   irq_dio_bank u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .port_addr(port_addr),
      .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
      .irq_req(irq_req), .dout(dout)
   );

   function automatic logic [8:0] wa(input logic [5:0] sel);
      return {1'b0, sel, 2'b10};
   endfunction

   function automatic logic [8:0] ra(input logic [5:0] sel);
      return {1'b0, sel, 2'b11};
   endfunction

   task automatic chk(input string req, input logic [25:0] act, input logic [25:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [25:0] d);
      @(negedge clk);
      port_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [8:0] a, output logic [25:0] d);
      @(negedge clk);
      port_addr = a; rd_en = 1'b1;
      #1 d = rd_data;
      rd_en = 1'b0;
   endtask

   task automatic pulse(input logic [11:0] m);
      @(negedge clk);
      irq_in = m;
      @(negedge clk);
      irq_in = '0;
      #1;
   endtask

   function automatic logic exp_req();
      return |(exp_lat & ~exp_inh);
   endfunction

   task automatic check_state(input string req);
      logic [25:0] d;
      rd(ra(6'd23), d);
      chk(req, d, {14'd0, exp_lat});
      rd(ra(6'd10), d);
      chk(req, d, {3'd0, exp_dout, exp_ss});
      chk(req, {25'd0, irq_req}, {25'd0, exp_req()});
      chk(req, {18'd0, dout}, {18'd0, exp_dout});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [25:0] d;
      logic [7:0]  lf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check_state("R1");

      // R2 each source individually, accumulating
      for (int i = 0; i < 12; i++) begin
         pulse(12'(1) << i);
         exp_lat[i] = 1'b1;
         rd(ra(6'd23), d);
         chk("R2", d, {14'd0, exp_lat});
         chk("R3", {25'd0, irq_req}, 26'd1);
      end

      // R2 held line does not relatch after clear
      @(negedge clk); irq_in = 12'h001;
      wr(wa(6'd6), 26'h3FFFFFF);
      exp_lat = '0;
      repeat (2) @(negedge clk);
      rd(ra(6'd23), d);
      chk("R2 held line", d, 26'd0);
      irq_in = '0;
      @(negedge clk);

      // R3 R4 full inhibit sweep against all-latched storage
      pulse(12'hFFF);
      exp_lat = 12'hFFF;
      for (int m = 0; m < 4096; m++) begin
         wr(wa(6'd14), {14'h2AAA, 12'(m)});
         exp_inh = 12'(m);
         chk("R3 R4 mask", {25'd0, irq_req}, {25'd0, exp_req()});
         if ((m % 512) == 0) begin
            rd(ra(6'd23), d);
            chk("R4 storage kept", d, {14'd0, exp_lat});
         end
      end

      // R3 single source versus its own mask bit
      for (int k = 0; k < 12; k++) begin
         wr(wa(6'd6), 26'hFFF);
         exp_lat = '0;
         pulse(12'(1) << k);
         exp_lat = 12'(1) << k;
         wr(wa(6'd14), {14'd0, ~(12'(1) << k)});
         exp_inh = ~(12'(1) << k);
         chk("R3 unmasked", {25'd0, irq_req}, 26'd1);
         wr(wa(6'd14), {14'd0, 12'(1) << k});
         exp_inh = 12'(1) << k;
         chk("R3 masked", {25'd0, irq_req}, 26'd0);
      end

      // R5 partial clears
      wr(wa(6'd14), 26'd0); exp_inh = '0;
      pulse(12'hFFF); exp_lat = 12'hFFF;
      wr(wa(6'd6), 26'h3FFFA5A);
      exp_lat = exp_lat & ~12'hA5A;
      check_state("R5");
      wr(wa(6'd6), 26'h0000000);
      check_state("R5 zero clear");
      wr(wa(6'd6), 26'h00005A5);
      exp_lat = exp_lat & ~12'h5A5;
      check_state("R5");

      // R6 edge coincides with clear of the same bit
      pulse(12'hFFF); exp_lat = 12'hFFF;
      @(negedge clk);
      irq_in = 12'h008; port_addr = wa(6'd6); wr_data = 26'hFFF; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; irq_in = '0;
      #1;
      exp_lat = 12'h008;
      check_state("R6");

      // R7 discrete set/clear sequences
      lf = 8'h5B;
      for (int n = 0; n < 24; n++) begin
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         if (n[0]) begin
            wr(wa(6'd2), {18'h3FF00, lf});
            exp_dout = exp_dout & ~lf;
         end else begin
            wr(wa(6'd3), {18'h3FF00, lf});
            exp_dout = exp_dout | lf;
         end
         chk("R7", {18'd0, dout}, {18'd0, exp_dout});
      end

      // R8 switch-selector loads and combined readback
      for (int n = 0; n < 8; n++) begin
         wr(wa(6'd7), {11'h7FF, 15'(16'h1357 * (n + 3))});
         exp_ss = 15'(16'h1357 * (n + 3));
         rd(ra(6'd10), d);
         chk("R8", d, {3'd0, exp_dout, exp_ss});
      end

      // R9 wrong direction bits, unknown selectors, bit 8 ignored
      wr({1'b0, 6'd14, 2'b11}, 26'hFFF);
      wr({1'b0, 6'd6, 2'b00}, 26'hFFF);
      wr({1'b0, 6'd3, 2'b01}, 26'hFF);
      wr(wa(6'd5), 26'h3FFFFFF);
      wr(wa(6'd23), 26'h3FFFFFF);
      wr(wa(6'd10), 26'h3FFFFFF);
      check_state("R9 ignored");
      wr({1'b1, 6'd7, 2'b10}, 26'h0001234);
      exp_ss = 15'h1234;
      wr({1'b1, 6'd3, 2'b10}, 26'h00000FF);
      exp_dout = 8'hFF;
      check_state("R9 bit8");

      // R10 idle read bus and unknown read addresses
      #1 chk("R10 idle", rd_data, 26'd0);
      rd(ra(6'd14), d); chk("R10 unknown", d, 26'd0);
      rd(ra(6'd7), d);  chk("R10 unknown", d, 26'd0);
      rd({1'b0, 6'd23, 2'b10}, d); chk("R10 wrong dir", d, 26'd0);

      // R1 reset again clears everything
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      exp_lat = '0; exp_inh = '0; exp_dout = '0; exp_ss = '0;
      #1;
      check_state("R1 rereset");

      finish_run();
   end
endmodule